// File: doc/BRIEF.md
# Operand Bypass and Pipeline Interlock Controller

This block is the hazard control for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It is purely combinational. It looks at the source register numbers of the instructions in decode and execute. It also looks at the destination numbers, write-enable flags and load flags of the instructions further down the pipe. From these it decides where each operand should come from and whether the front of the pipe must wait.

For the two ALU operands in execute, it picks the register file or a bypass. The bypass can come from the execute/memory register, which holds the result one instruction older, or from the memory/writeback register, which holds the result two instructions older. Branches are resolved by a comparator in decode, so the block also picks bypass sources for the two comparator operands.

A load followed at once by a consumer of the loaded register raises a stall for one cycle. A branch whose operand is still being produced further down the pipe also raises a stall, for as many cycles as the producer needs. The stall holds the PC and the fetch/decode register and injects a zero-control bubble into execute. A branch that is not stalled squashes the instruction fetched behind it, which costs one bubble.

Top module: `hzd_fwd_ctl`

## Requirements
- R1: An execute operand whose register number equals `mem_rd` gets select 2'b10 (execute/memory bypass), provided `mem_wr_en` is 1 and `mem_rd` is not 0.
- R2: An execute operand whose register number equals `wb_rd` gets select 2'b01 (memory/writeback bypass), provided `wb_wr_en` is 1, `wb_rd` is not 0 and R1 does not apply. Otherwise the select is 2'b00 (register file).
- R3: When both the memory and writeback stages hold a matching, writing, non-zero destination, the execute/memory bypass (2'b10) wins. The select value 2'b11 never occurs.
- R4: Register 0 is never bypassed, and a stage whose write flag is 0 is never bypassed. In either case the select stays 2'b00.
- R5: When execute holds a writing load (`ex_is_load`=1, `ex_wr_en`=1) whose non-zero `ex_rd` equals either decode source, `stall` and `bubble` are both 1. `stall` and `bubble` are always equal.
- R6: One cycle after a load-use stall, the load sits in memory and a bubble sits in execute, and no stall is raised. One cycle after that, the dependent instruction is in execute and takes the loaded value with select 2'b01.
- R7: A branch in decode (`dec_is_branch`=1) that is not stalled raises `flush_ifid`. `flush_ifid` is never 1 without a branch in decode.
- R8: A branch in decode whose source matches the non-zero, writing destination of a non-load in execute raises `stall`. While stalled, `flush_ifid` is 0.
- R9: A branch in decode whose source matches a writing load in execute or in memory raises `stall`. The branch therefore waits two cycles behind a load that precedes it directly.
- R10: The decode comparator selects use the same encoding as the execute selects (10 memory, 01 writeback, 00 register file, memory first). A load in the memory stage is never a source for the comparator bypass.
- R11: A non-branch instruction that depends on a non-load result in execute raises no stall. A source match against a stage with its write flag clear raises no stall either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs_a | input | REG_W | First source register of the instruction in decode |
| dec_rs_b | input | REG_W | Second source register of the instruction in decode |
| dec_is_branch | input | 1 | Instruction in decode is a conditional branch |
| ex_rs_a | input | REG_W | First ALU source register of the instruction in execute |
| ex_rs_b | input | REG_W | Second ALU source register of the instruction in execute |
| ex_rd | input | REG_W | Destination register of the instruction in execute |
| ex_wr_en | input | 1 | Instruction in execute writes the register file |
| ex_is_load | input | 1 | Instruction in execute is a load |
| mem_rd | input | REG_W | Destination held in the execute/memory register |
| mem_wr_en | input | 1 | Register-write flag in the execute/memory register |
| mem_is_load | input | 1 | Memory-read flag in the execute/memory register |
| wb_rd | input | REG_W | Destination held in the memory/writeback register |
| wb_wr_en | input | 1 | Register-write flag in the memory/writeback register |
| fwd_sel_a | output | 2 | Operand A mux select in execute |
| fwd_sel_b | output | 2 | Operand B mux select in execute |
| brf_sel_a | output | 2 | Comparator operand A select in decode |
| brf_sel_b | output | 2 | Comparator operand B select in decode |
| stall | output | 1 | Hold PC and the fetch/decode register |
| bubble | output | 1 | Zero the control bits entering execute |
| flush_ifid | output | 1 | Squash the fetch/decode register behind a branch |

## Verification
The bypass selects are driven with a source that matches only the memory stage, only the writeback stage, both stages, or neither. These cases separate a correct priority from a reversed one and from a missing bypass path. The same cases are repeated with register 0 and with write flags cleared, which exposes any bypass that ignores the qualifiers.

The interlock is tried with four producers ahead of a consumer: a load, an ALU op, a branch behind an ALU op, and a branch behind a load in execute or memory. This tells apart a stall that is too broad, one that is missing, and one that fails to block the flush.

A short cycle sequence then replays a load-use pair through the bubble, to confirm that the loaded value arrives through the writeback bypass.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  // Operand source select encoding shared by execute and decode muxes
  localparam logic [1:0] SEL_RF   = 2'b00;
  localparam logic [1:0] SEL_NEAR = 2'b10;  // execute/memory register
  localparam logic [1:0] SEL_FAR  = 2'b01;  // memory/writeback register
endpackage

// File: rtl/hzd_fwd_pick.sv
module hzd_fwd_pick #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] near_rd,
  input  logic             near_ok,
  input  logic [REG_W-1:0] far_rd,
  input  logic             far_ok,
  output logic [1:0]       sel
);
  import hzd_pkg::*;

  function automatic logic reg_hit(logic [REG_W-1:0] s, logic [REG_W-1:0] d, logic ok);
    return ok && (d != '0) && (s == d);
  endfunction

  logic near_hit;
  logic far_hit;

  assign near_hit = reg_hit(src, near_rd, near_ok);
  assign far_hit  = reg_hit(src, far_rd, far_ok);

  always_comb begin
    if (near_hit)     sel = SEL_NEAR;
    else if (far_hit) sel = SEL_FAR;
    else              sel = SEL_RF;
  end
endmodule

// File: rtl/hzd_stall_ctl.sv
module hzd_stall_ctl #(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic [REG_W-1:0] dec_src [NUM_SRC],
  input  logic             dec_is_branch,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_wr_en,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_wr_en,
  input  logic             mem_is_load,
  output logic             load_use_hit,
  output logic             br_ex_hit,
  output logic             br_mload_hit,
  output logic             stall,
  output logic             bubble,
  output logic             flush
);
  function automatic logic reg_hit(logic [REG_W-1:0] s, logic [REG_W-1:0] d, logic ok);
    return ok && (d != '0) && (s == d);
  endfunction

  logic ex_any;
  logic mload_any;

  always_comb begin
    ex_any    = 1'b0;
    mload_any = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      ex_any    = ex_any    | reg_hit(dec_src[i], ex_rd, ex_wr_en);
      mload_any = mload_any | reg_hit(dec_src[i], mem_rd, mem_wr_en && mem_is_load);
    end
  end

  assign load_use_hit = ex_any & ex_is_load;
  assign br_ex_hit    = ex_any & dec_is_branch & ~ex_is_load;
  assign br_mload_hit = mload_any & dec_is_branch;
  assign stall        = load_use_hit | br_ex_hit | br_mload_hit;
  assign bubble       = stall;
  assign flush        = dec_is_branch & ~stall;
endmodule

// File: rtl/hzd_fwd_ctl.sv
module hzd_fwd_ctl #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] dec_rs_a,
  input  logic [REG_W-1:0] dec_rs_b,
  input  logic             dec_is_branch,
  input  logic [REG_W-1:0] ex_rs_a,
  input  logic [REG_W-1:0] ex_rs_b,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_wr_en,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_wr_en,
  input  logic             mem_is_load,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_wr_en,
  output logic [1:0]       fwd_sel_a,
  output logic [1:0]       fwd_sel_b,
  output logic [1:0]       brf_sel_a,
  output logic [1:0]       brf_sel_b,
  output logic             stall,
  output logic             bubble,
  output logic             flush_ifid
);
  localparam int unsigned NUM_SRC = 2;

  logic [REG_W-1:0] ex_src  [NUM_SRC];
  logic [REG_W-1:0] dec_src [NUM_SRC];
  logic [1:0]       ex_sel  [NUM_SRC];
  logic [1:0]       dec_sel [NUM_SRC];

  // Named internal events, visible to the bound checker
  logic mem_alu_wr;
  logic load_use_hit;
  logic br_ex_hit;
  logic br_mload_hit;

  assign ex_src[0]  = ex_rs_a;
  assign ex_src[1]  = ex_rs_b;
  assign dec_src[0] = dec_rs_a;
  assign dec_src[1] = dec_rs_b;

  // Loaded data is not ready at the decode comparator while in memory
  assign mem_alu_wr = mem_wr_en & ~mem_is_load;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    hzd_fwd_pick #(.REG_W(REG_W)) u_ex_pick (
      .src     (ex_src[g]),
      .near_rd (mem_rd),
      .near_ok (mem_wr_en),
      .far_rd  (wb_rd),
      .far_ok  (wb_wr_en),
      .sel     (ex_sel[g])
    );
    hzd_fwd_pick #(.REG_W(REG_W)) u_dec_pick (
      .src     (dec_src[g]),
      .near_rd (mem_rd),
      .near_ok (mem_alu_wr),
      .far_rd  (wb_rd),
      .far_ok  (wb_wr_en),
      .sel     (dec_sel[g])
    );
  end

  hzd_stall_ctl #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_stall (
    .dec_src       (dec_src),
    .dec_is_branch (dec_is_branch),
    .ex_rd         (ex_rd),
    .ex_wr_en      (ex_wr_en),
    .ex_is_load    (ex_is_load),
    .mem_rd        (mem_rd),
    .mem_wr_en     (mem_wr_en),
    .mem_is_load   (mem_is_load),
    .load_use_hit  (load_use_hit),
    .br_ex_hit     (br_ex_hit),
    .br_mload_hit  (br_mload_hit),
    .stall         (stall),
    .bubble        (bubble),
    .flush         (flush_ifid)
  );

  assign fwd_sel_a = ex_sel[0];
  assign fwd_sel_b = ex_sel[1];
  assign brf_sel_a = dec_sel[0];
  assign brf_sel_b = dec_sel[1];
endmodule

// File: rtl/hzd_fwd_ctl_chk.sv
module hzd_fwd_ctl_chk #(
  parameter int unsigned REG_W = 5
) (
  input logic [REG_W-1:0] dec_rs_a,
  input logic [REG_W-1:0] dec_rs_b,
  input logic             dec_is_branch,
  input logic [REG_W-1:0] ex_rs_a,
  input logic [REG_W-1:0] ex_rd,
  input logic             ex_wr_en,
  input logic             ex_is_load,
  input logic [1:0]       fwd_sel_a,
  input logic [1:0]       fwd_sel_b,
  input logic [1:0]       brf_sel_a,
  input logic             stall,
  input logic             bubble,
  input logic             flush_ifid
);
  logic ex_dec_match;
  assign ex_dec_match = ex_wr_en && (ex_rd != '0) &&
                        ((ex_rd == dec_rs_a) || (ex_rd == dec_rs_b));

  always_comb begin
    AST_STALL_IS_BUBBLE: assert (stall == bubble) else $error("stall/bubble differ"); // R5
    AST_SEL_A_LEGAL: assert (fwd_sel_a != 2'b11) else $error("illegal select a"); // R3
    AST_SEL_B_LEGAL: assert (fwd_sel_b != 2'b11) else $error("illegal select b"); // R3
    AST_BRF_A_LEGAL: assert (brf_sel_a != 2'b11) else $error("illegal comparator select"); // R10
    AST_ZERO_SRC_RF: assert (ex_rs_a != '0 || fwd_sel_a == 2'b00) else $error("r0 bypassed"); // R4
    AST_FLUSH_NEEDS_BRANCH: assert (!flush_ifid || dec_is_branch) else $error("flush w/o branch"); // R7
    AST_NO_FLUSH_IN_STALL: assert (!(flush_ifid && stall)) else $error("flush while stalled"); // R8
    AST_LOAD_USE_STALL: assert (!(ex_is_load && ex_dec_match) || stall) else $error("load-use missed"); // R5
    AST_BRANCH_EX_STALL: assert (!(dec_is_branch && ex_dec_match) || stall) else $error("branch hazard missed"); // R8
  end
endmodule

bind hzd_fwd_ctl hzd_fwd_ctl_chk #(.REG_W(REG_W)) chk_i (
  .dec_rs_a      (dec_rs_a),
  .dec_rs_b      (dec_rs_b),
  .dec_is_branch (dec_is_branch),
  .ex_rs_a       (ex_rs_a),
  .ex_rd         (ex_rd),
  .ex_wr_en      (ex_wr_en),
  .ex_is_load    (ex_is_load),
  .fwd_sel_a     (fwd_sel_a),
  .fwd_sel_b     (fwd_sel_b),
  .brf_sel_a     (brf_sel_a),
  .stall         (stall),
  .bubble        (bubble),
  .flush_ifid    (flush_ifid)
);

// File: tb/hzd_fwd_ctl_tb_top.sv
module hzd_fwd_ctl_tb_top;
  localparam int unsigned RW = 5;

  typedef struct packed {
    logic [RW-1:0] da, db;
    logic          br;
    logic [RW-1:0] ea, eb, erd;
    logic          ewe, eld;
    logic [RW-1:0] mrd;
    logic          mwe, mld;
    logic [RW-1:0] wrd;
    logic          wwe;
    logic [1:0]    fa, fb, xa, xb;
    logic          st, bu, fl;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{5'd0,5'd0,1'b0, 5'd3,5'd4,5'd0,1'b0,1'b0, 5'd3,1'b1,1'b0, 5'd0,1'b0, 2'b10,2'b00,2'b00,2'b00,1'b0,1'b0,1'b0, 4'd1}, // R1 operand a
    '{5'd0,5'd0,1'b0, 5'd1,5'd7,5'd0,1'b0,1'b0, 5'd7,1'b1,1'b0, 5'd0,1'b0, 2'b00,2'b10,2'b00,2'b00,1'b0,1'b0,1'b0, 4'd1}, // R1 operand b
    '{5'd0,5'd0,1'b0, 5'd9,5'd2,5'd0,1'b0,1'b0, 5'd0,1'b0,1'b0, 5'd9,1'b1, 2'b01,2'b00,2'b00,2'b00,1'b0,1'b0,1'b0, 4'd2}, // R2
    '{5'd0,5'd0,1'b0, 5'd5,5'd5,5'd0,1'b0,1'b0, 5'd5,1'b1,1'b0, 5'd5,1'b1, 2'b10,2'b10,2'b00,2'b00,1'b0,1'b0,1'b0, 4'd3}, // R3 priority
    '{5'd0,5'd0,1'b0, 5'd5,5'd0,5'd0,1'b0,1'b0, 5'd5,1'b0,1'b0, 5'd5,1'b1, 2'b01,2'b00,2'b00,2'b00,1'b0,1'b0,1'b0, 4'd3}, // R3 near not writing
    '{5'd0,5'd0,1'b0, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd0,1'b1,1'b0, 5'd0,1'b1, 2'b00,2'b00,2'b00,2'b00,1'b0,1'b0,1'b0, 4'd4}, // R4 register 0
    '{5'd0,5'd0,1'b0, 5'd6,5'd6,5'd0,1'b0,1'b0, 5'd6,1'b0,1'b0, 5'd6,1'b0, 2'b00,2'b00,2'b00,2'b00,1'b0,1'b0,1'b0, 4'd4}, // R4 write flags clear
    '{5'd8,5'd1,1'b0, 5'd0,5'd0,5'd8,1'b1,1'b1, 5'd0,1'b0,1'b0, 5'd0,1'b0, 2'b00,2'b00,2'b00,2'b00,1'b1,1'b1,1'b0, 4'd5}, // R5 via source a
    '{5'd2,5'd8,1'b0, 5'd0,5'd0,5'd8,1'b1,1'b1, 5'd0,1'b0,1'b0, 5'd0,1'b0, 2'b00,2'b00,2'b00,2'b00,1'b1,1'b1,1'b0, 4'd5}, // R5 via source b
    '{5'd8,5'd1,1'b0, 5'd0,5'd0,5'd8,1'b1,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0, 2'b00,2'b00,2'b00,2'b00,1'b0,1'b0,1'b0, 4'd11}, // R11 ALU producer
    '{5'd0,5'd3,1'b0, 5'd0,5'd0,5'd0,1'b1,1'b1, 5'd0,1'b0,1'b0, 5'd0,1'b0, 2'b00,2'b00,2'b00,2'b00,1'b0,1'b0,1'b0, 4'd5}, // R5 load to r0
    '{5'd1,5'd2,1'b1, 5'd0,5'd0,5'd3,1'b1,1'b0, 5'd4,1'b1,1'b0, 5'd5,1'b1, 2'b00,2'b00,2'b00,2'b00,1'b0,1'b0,1'b1, 4'd7}, // R7 clean branch
    '{5'd4,5'd1,1'b1, 5'd0,5'd0,5'd4,1'b1,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0, 2'b00,2'b00,2'b00,2'b00,1'b1,1'b1,1'b0, 4'd8}, // R8 branch on ALU in ex
    '{5'd1,5'd4,1'b1, 5'd0,5'd0,5'd4,1'b1,1'b1, 5'd0,1'b0,1'b0, 5'd0,1'b0, 2'b00,2'b00,2'b00,2'b00,1'b1,1'b1,1'b0, 4'd9}, // R9 load in ex
    '{5'd4,5'd1,1'b1, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd4,1'b1,1'b1, 5'd0,1'b0, 2'b00,2'b00,2'b00,2'b00,1'b1,1'b1,1'b0, 4'd9}, // R9 load in mem
    '{5'd4,5'd1,1'b1, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd4,1'b1,1'b0, 5'd0,1'b0, 2'b00,2'b00,2'b10,2'b00,1'b0,1'b0,1'b1, 4'd10}, // R10 mem bypass
    '{5'd1,5'd6,1'b1, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0,1'b0, 5'd6,1'b1, 2'b00,2'b00,2'b00,2'b01,1'b0,1'b0,1'b1, 4'd10}, // R10 wb bypass
    '{5'd2,5'd3,1'b1, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd2,1'b1,1'b0, 5'd2,1'b1, 2'b00,2'b00,2'b10,2'b00,1'b0,1'b0,1'b1, 4'd10}, // R10 priority
    '{5'd4,5'd1,1'b1, 5'd0,5'd0,5'd4,1'b0,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0, 2'b00,2'b00,2'b00,2'b00,1'b0,1'b0,1'b1, 4'd11}  // R11 non-writing producer
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [RW-1:0] dec_rs_a = '0, dec_rs_b = '0, ex_rs_a = '0, ex_rs_b = '0;
  logic [RW-1:0] ex_rd = '0, mem_rd = '0, wb_rd = '0;
  logic dec_is_branch = 1'b0, ex_wr_en = 1'b0, ex_is_load = 1'b0;
  logic mem_wr_en = 1'b0, mem_is_load = 1'b0, wb_wr_en = 1'b0;
  logic [1:0] fwd_sel_a, fwd_sel_b, brf_sel_a, brf_sel_b;
  logic stall, bubble, flush_ifid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  hzd_fwd_ctl #(.REG_W(RW)) dut_i (
    .dec_rs_a(dec_rs_a), .dec_rs_b(dec_rs_b), .dec_is_branch(dec_is_branch),
    .ex_rs_a(ex_rs_a), .ex_rs_b(ex_rs_b), .ex_rd(ex_rd), .ex_wr_en(ex_wr_en),
    .ex_is_load(ex_is_load), .mem_rd(mem_rd), .mem_wr_en(mem_wr_en),
    .mem_is_load(mem_is_load), .wb_rd(wb_rd), .wb_wr_en(wb_wr_en),
    .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b), .brf_sel_a(brf_sel_a),
    .brf_sel_b(brf_sel_b), .stall(stall), .bubble(bubble), .flush_ifid(flush_ifid)
  );

  task automatic drive(input vec_t v);
    dec_rs_a = v.da; dec_rs_b = v.db; dec_is_branch = v.br;
    ex_rs_a = v.ea; ex_rs_b = v.eb; ex_rd = v.erd; ex_wr_en = v.ewe; ex_is_load = v.eld;
    mem_rd = v.mrd; mem_wr_en = v.mwe; mem_is_load = v.mld;
    wb_rd = v.wrd; wb_wr_en = v.wwe;
  endtask

  task automatic check_out(input vec_t v, input string tag);
    logic [10:0] act, exp;
    act = {fwd_sel_a, fwd_sel_b, brf_sel_a, brf_sel_b, stall, bubble, flush_ifid};
    exp = {v.fa, v.fb, v.xa, v.xb, v.st, v.bu, v.fl};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %b expected %b (fa fb xa xb st bu fl)", v.req, tag, act, exp);
    end
  endtask

  // Runs one cycle: drive after the falling edge, sample mid-phase
  task automatic step(input vec_t v, input string tag);
    @(negedge clk);
    drive(v);
    #5;
    check_out(v, tag);
  endtask

  initial begin
    vec_t z;
    vec_t s;
    z = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // R4 reset-like idle state: all inputs zero give all outputs zero
    s = z; s.req = 4'd4;
    step(s, "idle");

    for (int i = 0; i < NV; i++) step(VECS[i], $sformatf("vector %0d", i));

    // R6 sequence: load r8 in ex, consumer in decode
    s = z; s.da = 5'd8; s.erd = 5'd8; s.ewe = 1'b1; s.eld = 1'b1;
    s.st = 1'b1; s.bu = 1'b1; s.req = 4'd6;
    step(s, "R6 load-use stall");
    s = z; s.da = 5'd8; s.mrd = 5'd8; s.mwe = 1'b1; s.mld = 1'b1; s.req = 4'd6;
    step(s, "R6 bubble in ex");
    s = z; s.ea = 5'd8; s.wrd = 5'd8; s.wwe = 1'b1; s.fa = 2'b01; s.req = 4'd6;
    step(s, "R6 consumer gets loaded value");

    // R9 sequence: branch right behind a load waits two cycles, then bypasses
    s = z; s.br = 1'b1; s.da = 5'd7; s.erd = 5'd7; s.ewe = 1'b1; s.eld = 1'b1;
    s.st = 1'b1; s.bu = 1'b1; s.req = 4'd9;
    step(s, "R9 first wait");
    s = z; s.br = 1'b1; s.da = 5'd7; s.mrd = 5'd7; s.mwe = 1'b1; s.mld = 1'b1;
    s.st = 1'b1; s.bu = 1'b1; s.req = 4'd9;
    step(s, "R9 second wait");
    s = z; s.br = 1'b1; s.da = 5'd7; s.wrd = 5'd7; s.wwe = 1'b1;
    s.xa = 2'b01; s.fl = 1'b1; s.req = 4'd9;
    step(s, "R9 released");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule